// File: doc/BRIEF.md
# Carry-Save Residue Arithmetic Channel

This block is one arithmetic lane of a residue number system datapath, working modulo 2^N − 1. It takes residue operands that are each kept as an unresolved pair of vectors, a sum vector S and a carry vector C. It returns its result in the same pair form, so no carry-propagating adder appears anywhere in the lane. The value a pair stands for is S + 2C modulo 2^N − 1. Because 2^N is congruent to 1, doubling C is a one-place left rotation, and the carry vector's top bit wraps to bit 0.

A request carries a valid strobe, a two-bit operation code and up to three operands. The lane can add two residues, subtract one from another, multiply two, or add three in a single pass. Inside, every operand is split into its two vectors, and each vector becomes a separate addend. For a product, one rotated copy of the multiplicand is made for each set bit of the multiplier. A chain of end-around carry-save cells then reduces all addends to one S/C pair. A bit that would leave the top of a vector re-enters at bit 0, because a weight of 2^(i+N·j) equals 2^i under this modulus. The result is registered, and an output valid follows the request one cycle later.

Both the all-zeros and the all-ones N-bit patterns denote residue 0. Only a later consumer that needs a canonical value has to resolve a pair.

Top module: `rns_cs_channel`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly one clock; a request's result appears on `out_s`/`out_c` at the first rising edge after it is presented.
- R2: With `in_op` = 0 (add), (out_s + 2·out_c) mod (2^N − 1) equals (A + B) mod (2^N − 1).
- R3: With `in_op` = 1 (subtract), the result value equals (A − B) mod (2^N − 1), including cases where B exceeds A.
- R4: With `in_op` = 2 (multiply), the result value equals (A · B) mod (2^N − 1), including 2^N − 2 times 2^N − 2, which gives 1.
- R5: With `in_op` = 3 (three-operand add), the result value equals (A + B + Cop) mod (2^N − 1).
- R6: The value of an operand or result pair (s, c) is s + rotl(c, 1) taken modulo 2^N − 1, so bit N−1 of c carries weight 1. The all-ones and all-zeros patterns both stand for 0.
- R7: While `in_valid` is low, `out_s` and `out_c` keep their previous values.
- R8: A synchronous active-high `rst` clears `out_valid`, `out_s` and `out_c` to zero on the next rising edge.
- R9: The third operand (`c_s`, `c_c`) has no effect on the result when `in_op` is 0, 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | 0 add, 1 subtract, 2 multiply, 3 three-operand add |
| a_s | input | N | Operand A sum vector |
| a_c | input | N | Operand A carry vector |
| b_s | input | N | Operand B sum vector |
| b_c | input | N | Operand B carry vector |
| c_s | input | N | Third operand sum vector |
| c_c | input | N | Third operand carry vector |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_s | output | N | Result sum vector |
| out_c | output | N | Result carry vector |

## Verification
Suppose one reduction cell drops its wrapped carry, or one addend of a product is rotated by the wrong amount. The registered pair would then resolve to a value off by a power of two modulo 2^N − 1. That error shows on the very next clock after the affected request, but only for operands that exercise the faulty bit. For this reason the vectors include carries with the top bit set, the all-ones zero, and the 2^N − 2 corner. A hold or valid fault appears on the first idle cycle after a request.

// File: rtl/rns_cs_pkg.sv
package rns_cs_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_MUL  = 2'd2,
        OP_ADD3 = 2'd3
    } rns_op_e;

    // Number of addends the add/subtract path feeds into its reducer:
    // two vectors per operand, three operands.
    localparam int ADD_TERMS = 6;

    function automatic logic op_is_mul(input rns_op_e op);
        return op == OP_MUL;
    endfunction

    function automatic logic op_is_sub(input rns_op_e op);
        return op == OP_SUB;
    endfunction

    function automatic logic op_uses_third(input rns_op_e op);
        return op == OP_ADD3;
    endfunction

endpackage

// File: rtl/rns_eac_csa.sv
module rns_eac_csa #(
    parameter int N = 8
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    input  logic [N-1:0] z,
    output logic [N-1:0] sum,
    output logic [N-1:0] cry
);
    localparam longint MOD = (longint'(1) << N) - 1;

    always_comb begin
        sum = x ^ y ^ z;
        cry = (x & y) | (x & z) | (y & z);
    end

    // R6: a cell keeps the residue; carry weight doubles with end-around wrap.
    always_comb begin
        p_cell_value_r6: assert (((longint'(x) + longint'(y) + longint'(z)) % MOD) ==
                                 ((longint'(sum) + longint'({cry[N-2:0], cry[N-1]})) % MOD));
    end

endmodule

// File: rtl/rns_csa_tree.sv
module rns_csa_tree #(
    parameter int N = 8,
    parameter int K = 6
) (
    input  logic [K-1:0][N-1:0] terms,
    output logic [N-1:0]        out_s,
    output logic [N-1:0]        out_c
);
    localparam int STAGES = K - 2;

    logic [STAGES-1:0][N-1:0] st_s;
    logic [STAGES-1:0][N-1:0] st_c;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                rns_eac_csa #(.N(N)) u_cell (
                    .x  (terms[0]),
                    .y  (terms[1]),
                    .z  (terms[2]),
                    .sum(st_s[i]),
                    .cry(st_c[i])
                );
            end else begin : g_next
                logic [N-1:0] dbl;
                assign dbl = {st_c[i-1][N-2:0], st_c[i-1][N-1]};
                rns_eac_csa #(.N(N)) u_cell (
                    .x  (st_s[i-1]),
                    .y  (dbl),
                    .z  (terms[i+2]),
                    .sum(st_s[i]),
                    .cry(st_c[i])
                );
            end
        end
    endgenerate

    assign out_s = st_s[STAGES-1];
    assign out_c = st_c[STAGES-1];

endmodule

// File: rtl/rns_cs_addsub.sv
module rns_cs_addsub
    import rns_cs_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         sub_en,
    input  logic         third_en,
    input  logic [N-1:0] a_s,
    input  logic [N-1:0] a_c,
    input  logic [N-1:0] b_s,
    input  logic [N-1:0] b_c,
    input  logic [N-1:0] c_s,
    input  logic [N-1:0] c_c,
    output logic [N-1:0] res_s,
    output logic [N-1:0] res_c
);
    localparam longint MOD = (longint'(1) << N) - 1;

    function automatic logic [N-1:0] rot1(input logic [N-1:0] v);
        return {v[N-2:0], v[N-1]};
    endfunction

    function automatic longint pair_val(input logic [N-1:0] s, input logic [N-1:0] c);
        return (longint'(s) + longint'(rot1(c))) % MOD;
    endfunction

    logic [ADD_TERMS-1:0][N-1:0] terms;
    logic [N-1:0]                inv_mask;
    logic [N-1:0]                third_mask;

    always_comb begin
        inv_mask   = {N{sub_en}};
        third_mask = {N{third_en}};
        terms[0]   = a_s;
        terms[1]   = rot1(a_c);
        // One's-complement inversion is the negative modulo 2^N-1.
        terms[2]   = b_s ^ inv_mask;
        terms[3]   = rot1(b_c) ^ inv_mask;
        terms[4]   = c_s & third_mask;
        terms[5]   = rot1(c_c) & third_mask;
    end

    rns_csa_tree #(.N(N), .K(ADD_TERMS)) u_tree (
        .terms(terms),
        .out_s(res_s),
        .out_c(res_c)
    );

    // R2, R3, R5: residue of the reduced pair matches the integer operation.
    always_comb begin
        if (sub_en) begin
            p_sub_value_r3: assert (pair_val(res_s, res_c) ==
                                    (pair_val(a_s, a_c) + MOD - pair_val(b_s, b_c)) % MOD);
        end else if (third_en) begin
            p_add3_value_r5: assert (pair_val(res_s, res_c) ==
                                     (pair_val(a_s, a_c) + pair_val(b_s, b_c) +
                                      pair_val(c_s, c_c)) % MOD);
        end else begin
            p_add_value_r2: assert (pair_val(res_s, res_c) ==
                                    (pair_val(a_s, a_c) + pair_val(b_s, b_c)) % MOD);
        end
    end

endmodule

// File: rtl/rns_cs_mult.sv
module rns_cs_mult #(
    parameter int N = 8
) (
    input  logic [N-1:0] a_s,
    input  logic [N-1:0] a_c,
    input  logic [N-1:0] b_s,
    input  logic [N-1:0] b_c,
    output logic [N-1:0] res_s,
    output logic [N-1:0] res_c
);
    localparam longint MOD    = (longint'(1) << N) - 1;
    localparam int     VECS   = 2;
    localparam int     NTERMS = VECS * VECS * N;

    function automatic logic [N-1:0] rot1(input logic [N-1:0] v);
        return {v[N-2:0], v[N-1]};
    endfunction

    function automatic logic [N-1:0] rotk(input logic [N-1:0] v, input int k);
        if (k == 0) return v;
        return (v << k) | (v >> (N - k));
    endfunction

    function automatic longint pair_val(input logic [N-1:0] s, input logic [N-1:0] c);
        return (longint'(s) + longint'(rot1(c))) % MOD;
    endfunction

    logic [VECS-1:0][N-1:0] mcand;
    logic [VECS-1:0][N-1:0] mplier;
    logic [NTERMS-1:0][N-1:0] pp;

    assign mcand[0]  = a_s;
    assign mcand[1]  = rot1(a_c);
    assign mplier[0] = b_s;
    assign mplier[1] = rot1(b_c);

    generate
        for (genvar i = 0; i < VECS; i++) begin : g_md
            for (genvar j = 0; j < VECS; j++) begin : g_mr
                for (genvar k = 0; k < N; k++) begin : g_bit
                    // Multiplicand times 2^k modulo 2^N-1 is a k-place rotation.
                    assign pp[(i * VECS + j) * N + k] =
                        mplier[j][k] ? rotk(mcand[i], k) : '0;
                end
            end
        end
    endgenerate

    rns_csa_tree #(.N(N), .K(NTERMS)) u_tree (
        .terms(pp),
        .out_s(res_s),
        .out_c(res_c)
    );

    // R4: product residue.
    always_comb begin
        p_mul_value_r4: assert (pair_val(res_s, res_c) ==
                                (pair_val(a_s, a_c) * pair_val(b_s, b_c)) % MOD);
    end

endmodule

// File: rtl/rns_cs_channel.sv
module rns_cs_channel
    import rns_cs_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [1:0]   in_op,
    input  logic [N-1:0] a_s,
    input  logic [N-1:0] a_c,
    input  logic [N-1:0] b_s,
    input  logic [N-1:0] b_c,
    input  logic [N-1:0] c_s,
    input  logic [N-1:0] c_c,
    output logic         out_valid,
    output logic [N-1:0] out_s,
    output logic [N-1:0] out_c
);
    rns_op_e      op;
    logic [N-1:0] add_s, add_c;
    logic [N-1:0] mul_s, mul_c;
    logic [N-1:0] nxt_s, nxt_c;

    assign op = rns_op_e'(in_op);

    rns_cs_addsub #(.N(N)) u_addsub (
        .sub_en  (op_is_sub(op)),
        .third_en(op_uses_third(op)),
        .a_s     (a_s),
        .a_c     (a_c),
        .b_s     (b_s),
        .b_c     (b_c),
        .c_s     (c_s),
        .c_c     (c_c),
        .res_s   (add_s),
        .res_c   (add_c)
    );

    rns_cs_mult #(.N(N)) u_mult (
        .a_s  (a_s),
        .a_c  (a_c),
        .b_s  (b_s),
        .b_c  (b_c),
        .res_s(mul_s),
        .res_c(mul_c)
    );

    always_comb begin
        if (op_is_mul(op)) begin
            nxt_s = mul_s;
            nxt_c = mul_c;
        end else begin
            nxt_s = add_s;
            nxt_c = add_c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_s     <= '0;
            out_c     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_s <= nxt_s;
                out_c <= nxt_c;
            end
        end
    end

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_no_valid_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_s) && $stable(out_c)));

    p_reset_clears_r8: assert property (@(posedge clk)
        rst |=> (!out_valid && out_s == '0 && out_c == '0));

endmodule

// File: tb/rns_cs_channel_tb.sv
module rns_cs_channel_tb;
    localparam int     N   = 8;
    localparam longint MOD = (longint'(1) << N) - 1;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [1:0]   in_op;
    logic [N-1:0] a_s, a_c, b_s, b_c, c_s, c_c;
    logic         out_valid;
    logic [N-1:0] out_s, out_c;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rns_cs_channel #(.N(N)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .a_s(a_s), .a_c(a_c), .b_s(b_s), .b_c(b_c), .c_s(c_s), .c_c(c_c),
        .out_valid(out_valid), .out_s(out_s), .out_c(out_c)
    );

    typedef struct packed {
        logic [1:0] op;
        logic [7:0] as_, ac_, bs_, bc_, cs_, cc_;
        logic [7:0] want;
    } vec_t;

    // Op codes: 0 add, 1 sub, 2 mul, 3 three-operand add. Value = s + rotl(c,1) mod 255.
    localparam vec_t VECS [12] = '{
        '{2'd0, 8'd10,  8'd0,   8'd20,  8'd0, 8'd0,   8'd0,   8'd30},
        '{2'd0, 8'd0,   8'd5,   8'd3,   8'd0, 8'd99,  8'd7,   8'd13},
        '{2'd1, 8'd50,  8'd0,   8'd20,  8'd0, 8'd0,   8'd0,   8'd30},
        '{2'd1, 8'd20,  8'd0,   8'd50,  8'd0, 8'd0,   8'd0,   8'd225},
        '{2'd2, 8'd12,  8'd0,   8'd11,  8'd0, 8'd0,   8'd0,   8'd132},
        '{2'd2, 8'd16,  8'd0,   8'd16,  8'd0, 8'd0,   8'd0,   8'd1},
        '{2'd3, 8'd100, 8'd0,   8'd100, 8'd0, 8'd100, 8'd0,   8'd45},
        '{2'd0, 8'd0,   8'h80,  8'd0,   8'd0, 8'd0,   8'd0,   8'd1},
        '{2'd0, 8'd254, 8'd0,   8'd1,   8'd0, 8'd0,   8'd0,   8'd0},
        '{2'd2, 8'd254, 8'd0,   8'd254, 8'd0, 8'd0,   8'd0,   8'd1},
        '{2'd1, 8'd255, 8'd0,   8'd0,   8'd0, 8'd0,   8'd0,   8'd0},
        '{2'd2, 8'd3,   8'd2,   8'd0,   8'd1, 8'd0,   8'd0,   8'd14}
    };

    function automatic logic [N-1:0] rotl1(input logic [N-1:0] v);
        return {v[N-2:0], v[N-1]};
    endfunction

    // Checking normaliser: resolves a pair to its canonical residue (all-ones -> 0).
    function automatic longint norm(input logic [N-1:0] s, input logic [N-1:0] c);
        return (longint'(s) + longint'(rotl1(c))) % MOD;
    endfunction

    function automatic string op_req(input logic [1:0] op);
        case (op)
            2'd0:    return "R2";
            2'd1:    return "R3";
            2'd2:    return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic longint ref_result(input logic [1:0] op, input longint x,
                                          input longint y, input longint z);
        case (op)
            2'd0:    return (x + y) % MOD;
            2'd1:    return (x + MOD - y) % MOD;
            2'd2:    return (x * y) % MOD;
            default: return (x + y + z) % MOD;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        in_valid = 1'b0;
        in_op = 2'd0;
        a_s = '0; a_c = '0; b_s = '0; b_c = '0; c_s = '0; c_c = '0;
    endtask

    // Present one request at a falling edge; result is sampled at the next falling edge.
    task automatic run_op(input logic [1:0] op,
                          input logic [N-1:0] as_, input logic [N-1:0] ac_,
                          input logic [N-1:0] bs_, input logic [N-1:0] bc_,
                          input logic [N-1:0] cs_, input logic [N-1:0] cc_);
        @(negedge clk);
        in_valid = 1'b1;
        in_op = op;
        a_s = as_; a_c = ac_; b_s = bs_; b_c = bc_; c_s = cs_; c_c = cc_;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        logic [N-1:0] hs, hc;
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R8: reset state
        check(out_valid == 1'b0, "R8 valid", longint'(out_valid), 0);
        check(out_s == '0 && out_c == '0, "R8 data", norm(out_s, out_c), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 idle", longint'(out_valid), 0);

        // Table of vectors (R6 covered by rows with carries, incl. top bit wrap)
        foreach (VECS[i]) begin
            run_op(VECS[i].op, VECS[i].as_, VECS[i].ac_, VECS[i].bs_,
                   VECS[i].bc_, VECS[i].cs_, VECS[i].cc_);
            check(out_valid == 1'b1, "R1 valid", longint'(out_valid), 1);
            check(norm(out_s, out_c) == longint'(VECS[i].want), op_req(VECS[i].op),
                  norm(out_s, out_c), longint'(VECS[i].want));
        end

        // R7: hold while idle, and R1 valid drops
        hs = out_s; hc = out_c;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 drop", longint'(out_valid), 0);
        check(out_s == hs && out_c == hc, "R7 hold", norm(out_s, out_c), norm(hs, hc));
        a_s = 8'd77; b_s = 8'd5; in_op = 2'd2;
        @(negedge clk);
        check(out_s == hs && out_c == hc, "R7 hold inputs moving",
              norm(out_s, out_c), norm(hs, hc));
        idle_inputs();

        // R9: third operand ignored for add, sub, mul
        for (int op = 0; op < 3; op++) begin
            run_op(op[1:0], 8'd40, 8'd3, 8'd9, 8'd1, 8'd200, 8'd131);
            check(norm(out_s, out_c) == ref_result(op[1:0], 46, 11, 0), "R9",
                  norm(out_s, out_c), ref_result(op[1:0], 46, 11, 0));
        end

        // Corners 0 and 2^N-2 across all ops (R6 zero encodings)
        for (int op = 0; op < 4; op++) begin
            for (int k = 0; k < 4; k++) begin
                logic [N-1:0] x, y;
                x = (k[0]) ? 8'd254 : ((k[1]) ? 8'd255 : 8'd0);
                y = (k[1]) ? 8'd254 : 8'd0;
                run_op(op[1:0], x, 8'd0, y, 8'd0, 8'd254, 8'd0);
                check(norm(out_s, out_c) ==
                      ref_result(op[1:0], norm(x, 8'd0), norm(y, 8'd0), 254),
                      op_req(op[1:0]), norm(out_s, out_c),
                      ref_result(op[1:0], norm(x, 8'd0), norm(y, 8'd0), 254));
            end
        end

        // Random operands in pair form (R6) over every op
        for (int t = 0; t < 400; t++) begin
            logic [N-1:0] r0, r1, r2, r3, r4, r5;
            logic [1:0]   rop;
            longint       exp_v;
            r0 = N'($urandom); r1 = N'($urandom); r2 = N'($urandom);
            r3 = N'($urandom); r4 = N'($urandom); r5 = N'($urandom);
            rop = 2'($urandom);
            exp_v = ref_result(rop, norm(r0, r1), norm(r2, r3), norm(r4, r5));
            run_op(rop, r0, r1, r2, r3, r4, r5);
            check(norm(out_s, out_c) == exp_v, "R6 random", norm(out_s, out_c), exp_v);
        end

        // R8: reset in mid-run clears a live result
        run_op(2'd0, 8'd9, 8'd0, 8'd9, 8'd0, 8'd0, 8'd0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(out_valid == 1'b0 && out_s == '0 && out_c == '0, "R8 mid-run",
              norm(out_s, out_c), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule